// File: doc/BRIEF.md
# Single-Buffer Serial Port Controller

This block is a byte-wide microprocessor-bus serial port with a one-byte transmit holding register and a one-byte receive register. There is no queue behind them. Software polls the status byte before every data access. A transmit shifter and a receive sampler serialize and deserialize 8N1 characters: one start bit, eight data bits sent least significant bit first, and one stop bit. Both are timed by a divider that the control register selects from a fixed table of sixteen rates. The divider values are computed from the system clock frequency when the design is elaborated.

The register interface has side effects. Any write to the status offset resets the buffers, and so does writing zero to the control register. The interrupt enables in the command register use inverted polarities. The status flags for receive-full and transmit-empty are held off for one character time after the most recent data read or data write. An active-high interrupt line reports the enabled conditions.

Top module: `byte_uart_port`

## Requirements
- R1: Reads decode as follows: offset 0 returns the receive register, offset 1 the status byte, offset 2 the last command value written, offset 3 the last control value written. After hardware reset, command and control both read 0x00.
- R2: The status byte has transmit-empty (shown) at bit 4, receive-full (shown) at bit 3 and overrun at bit 2; every other bit reads 0. After hardware reset the status reads 0x10, irq is 0 and txd is 1.
- R3: Control bits [3:0] pick a rate. Codes 1 to 15 map to 50, 75, 110, 135, 150, 300, 600, 1200, 1800, 2400, 3600, 4800, 7200, 9600 and 19200 baud. The tick divider is max(1, floor(CLK_HZ/(16*rate))), and every transmitted bit lasts 16*divider clock cycles.
- R4: With rate code 0 no character is sent or received. A written byte stays in the holding register (status bit 4 reads 0) and txd stays 1. Once a nonzero code is written, that byte is sent.
- R5: A transmitted frame is a start bit of 0, then data bits least significant first, then a stop bit of 1. A data write made while the holding register is occupied is ignored.
- R6: The receiver samples each bit at its midpoint, using 16 ticks per bit. A complete character is stored and sets receive-full. A data read clears receive-full.
- R7: If a character completes while receive-full is set, the overrun flag is set and the new character is dropped. A data read clears overrun.
- R8: The shown receive-full flag stays 0 for 160*divider cycles after a data read. The shown transmit-empty flag stays 0 for 160*divider cycles after a data write.
- R9: Any write to offset 1 clears both buffers, receive-full and overrun, leaves transmit-empty showing 1, and turns off both interrupt enables. The stored command value is left unchanged.
- R10: Writing 0x00 to offset 3 stores 0x00 and performs the same reset as R9.
- R11: A command write sets the receive interrupt enable when bit 1 is 0. It sets the transmit interrupt enable only when bit 2 is 1 and bit 3 is 0.
- R12: irq is 1 exactly when the shown receive-full flag and the receive enable are both 1, or when the shown transmit-empty flag and the transmit enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sel | input | 1 | Register access select |
| wr_en | input | 1 | Write strobe (qualified by sel) |
| rd_en | input | 1 | Read strobe (qualified by sel); triggers read side effects |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Active-high interrupt request |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
The bench builds the block with CLK_HZ set to 3,072,000. At that setting the fastest code gives a 10-cycle divider and a 1,600-cycle character. This keeps whole frames, hold-off windows, overrun pairs and a loopback sweep of sixteen byte values short enough to run. The same setting brings codes 9 through 15 within reach for exact bit-length timing. The command nibble is swept through all sixteen values to check the interrupt enable decoding.

// File: rtl/byte_uart_port.sv
module byte_uart_port #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       txd,
  input  logic       rxd
);

  localparam int DIV_MAX = (CLK_HZ / 800 < 1) ? 1 : CLK_HZ / 800;
  localparam int DW = $clog2(DIV_MAX + 1);
  localparam int HW = $clog2(160 * DIV_MAX + 1);

  function automatic int baud_of(input logic [3:0] c);
    case (c)
      4'd1:  return 50;
      4'd2:  return 75;
      4'd3:  return 110;
      4'd4:  return 135;
      4'd5:  return 150;
      4'd6:  return 300;
      4'd7:  return 600;
      4'd8:  return 1200;
      4'd9:  return 1800;
      4'd10: return 2400;
      4'd11: return 3600;
      4'd12: return 4800;
      4'd13: return 7200;
      4'd14: return 9600;
      4'd15: return 19200;
      default: return 0;
    endcase
  endfunction

  function automatic int div_of(input logic [3:0] c);
    int r;
    int d;
    r = baud_of(c);
    if (r == 0) return 0;
    d = CLK_HZ / (16 * r);
    return (d < 1) ? 1 : d;
  endfunction

  logic [7:0] ctrl_q, cmd_q, thr_q, rxbuf_q;
  logic       thr_full, rx_full, ovr, rx_en, tx_en;
  logic [HW-1:0] tx_hold, rx_hold;

  logic [DW-1:0] div;
  logic [HW-1:0] ctime;
  assign div   = DW'(div_of(ctrl_q[3:0]));
  assign ctime = HW'(160 * div_of(ctrl_q[3:0]));

  logic wr, rd_data, soft_rst;
  assign wr       = sel && wr_en;
  assign rd_data  = sel && rd_en && addr == 2'd0;
  assign soft_rst = wr && (addr == 2'd1 || (addr == 2'd3 && wdata == 8'h00));

  // transmit shifter
  logic          tx_busy, txd_q, tx_tick, tx_load;
  logic [DW-1:0] tx_cnt;
  logic [3:0]    tx_sub, tx_bit;
  logic [8:0]    tx_sh;

  assign tx_tick = tx_busy && div != '0 && tx_cnt >= div - DW'(1);
  assign tx_load = !tx_busy && thr_full && div != '0;
  assign txd     = txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy <= 1'b0;
      txd_q   <= 1'b1;
      tx_cnt  <= '0;
      tx_sub  <= '0;
      tx_bit  <= '0;
      tx_sh   <= '1;
    end else if (tx_load) begin
      tx_busy <= 1'b1;
      txd_q   <= 1'b0;
      tx_sh   <= {1'b1, thr_q};
      tx_cnt  <= '0;
      tx_sub  <= '0;
      tx_bit  <= '0;
    end else if (tx_busy) begin
      if (tx_tick) begin
        tx_cnt <= '0;
        if (tx_sub == 4'd15) begin
          tx_sub <= '0;
          if (tx_bit == 4'd9) begin
            tx_busy <= 1'b0;
          end else begin
            txd_q  <= tx_sh[0];
            tx_sh  <= {1'b1, tx_sh[8:1]};
            tx_bit <= tx_bit + 4'd1;
          end
        end else begin
          tx_sub <= tx_sub + 4'd1;
        end
      end else begin
        tx_cnt <= tx_cnt + DW'(1);
      end
    end
  end

  // receive sampler
  logic          rx_s1, rx_s2, rx_busy, rx_tick, rx_done;
  logic [DW-1:0] rx_cnt;
  logic [3:0]    rx_sub, rx_bit;
  logic [7:0]    rx_sh;

  assign rx_tick = rx_busy && div != '0 && rx_cnt >= div - DW'(1);
  assign rx_done = rx_tick && rx_bit == 4'd9 && rx_sub == 4'd15;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_busy <= 1'b0;
      rx_cnt  <= '0;
      rx_sub  <= '0;
      rx_bit  <= '0;
      rx_sh   <= '0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (!rx_busy) begin
        if (!rx_s2 && div != '0) begin
          rx_busy <= 1'b1;
          rx_cnt  <= '0;
          rx_sub  <= '0;
          rx_bit  <= '0;
        end
      end else if (rx_tick) begin
        rx_cnt <= '0;
        rx_sub <= rx_sub + 4'd1;
        if (rx_bit == 4'd0) begin
          if (rx_sub == 4'd7) begin
            rx_sub <= '0;
            if (rx_s2) rx_busy <= 1'b0;
            else       rx_bit  <= 4'd1;
          end
        end else if (rx_sub == 4'd15) begin
          rx_sub <= '0;
          if (rx_bit == 4'd9) begin
            rx_busy <= 1'b0;
          end else begin
            rx_sh  <= {rx_s2, rx_sh[7:1]};
            rx_bit <= rx_bit + 4'd1;
          end
        end
      end else begin
        rx_cnt <= rx_cnt + DW'(1);
      end
    end
  end

  // registers and buffers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      cmd_q    <= '0;
      thr_q    <= '0;
      rxbuf_q  <= '0;
      thr_full <= 1'b0;
      rx_full  <= 1'b0;
      ovr      <= 1'b0;
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      tx_hold  <= '0;
      rx_hold  <= '0;
    end else begin
      if (tx_hold != '0) tx_hold <= tx_hold - HW'(1);
      if (rx_hold != '0) rx_hold <= rx_hold - HW'(1);
      if (tx_load) thr_full <= 1'b0;
      if (rd_data) begin
        rx_full <= 1'b0;
        ovr     <= 1'b0;
        rx_hold <= ctime;
      end
      if (rx_done) begin
        if (rx_full && !rd_data) begin
          ovr <= 1'b1;
        end else begin
          rxbuf_q <= rx_sh;
          rx_full <= 1'b1;
        end
      end
      if (wr) begin
        case (addr)
          2'd0: begin
            tx_hold <= ctime;
            if (!thr_full) begin
              thr_q    <= wdata;
              thr_full <= 1'b1;
            end
          end
          2'd2: begin
            cmd_q <= wdata;
            rx_en <= !wdata[1];
            tx_en <= wdata[2] && !wdata[3];
          end
          2'd3: ctrl_q <= wdata;
          default: ;
        endcase
      end
      if (soft_rst) begin
        thr_q    <= '0;
        rxbuf_q  <= '0;
        thr_full <= 1'b0;
        rx_full  <= 1'b0;
        ovr      <= 1'b0;
        rx_en    <= 1'b0;
        tx_en    <= 1'b0;
        tx_hold  <= '0;
        rx_hold  <= '0;
      end
    end
  end

  logic st_rxf, st_txe;
  assign st_rxf = rx_full && rx_hold == '0;
  assign st_txe = !thr_full && tx_hold == '0;
  assign irq    = (st_rxf && rx_en) || (st_txe && tx_en);

  always_comb begin
    case (addr)
      2'd0:    rdata = rxbuf_q;
      2'd1:    rdata = {3'b000, st_txe, st_rxf, ovr, 2'b00};
      2'd2:    rdata = cmd_q;
      default: rdata = ctrl_q;
    endcase
  end

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd1) |=> (!rx_full && !thr_full && !ovr && !rx_en && !tx_en));

  a_r10_ctrl_zero: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd3 && wdata == 8'h00) |=> (ctrl_q == 8'h00 && !rx_full && !thr_full && !rx_en && !tx_en));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !rx_done && !wr) |=> !rx_full);

  a_r7_overrun_set: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_full && !rd_data && !soft_rst) |=> ovr);

  a_r4_idle_line: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[3:0] == 4'd0 && !tx_busy) |=> txd);

  a_r8_tx_holdoff: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd0) |=> !st_txe);

  a_r5_ignored_write: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == 2'd0 && thr_full) |=> $stable(thr_q));

  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rx_en || tx_en));

endmodule

// File: tb/sim_byte_uart_port.sv
`timescale 1ns/1ps
module sim_byte_uart_port;
  localparam int CLK_HZ = 3_072_000;

  logic clk = 1'b0, rst = 1'b1;
  logic sel = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, txd, rxd, rxd_drv = 1'b1, loop_en = 1'b0;
  int vectors = 0, fails = 0;
  bit finished = 0;

  assign rxd = loop_en ? txd : rxd_drv;
  always #5 clk = ~clk;

  byte_uart_port #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .txd(txd), .rxd(rxd));

  function automatic int dv(input int c);
    int r;
    case (c)
      1: r = 50;    2: r = 75;    3: r = 110;   4: r = 135;
      5: r = 150;   6: r = 300;   7: r = 600;   8: r = 1200;
      9: r = 1800;  10: r = 2400; 11: r = 3600; 12: r = 4800;
      13: r = 7200; 14: r = 9600; 15: r = 19200;
      default: r = 0;
    endcase
    if (r == 0) return 0;
    return (CLK_HZ / (16 * r) < 1) ? 1 : CLK_HZ / (16 * r);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr_en = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd_en = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0; rd_en = 0;
  endtask

  task automatic wait_rx(output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      bus_rd(2'd1, s);
      if (s[3]) begin ok = 1; break; end
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input int d);
    rxd_drv = 0; repeat (16 * d) @(posedge clk);
    for (int i = 0; i < 8; i++) begin rxd_drv = b[i]; repeat (16 * d) @(posedge clk); end
    rxd_drv = 1; repeat (16 * d) @(posedge clk);
  endtask

  task automatic grab_frame(input int d, output logic [9:0] f);
    wait (txd == 1'b0);
    repeat (8 * d) @(posedge clk);
    for (int i = 0; i < 10; i++) begin
      #1 f[i] = txd;
      repeat (16 * d) @(posedge clk);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [9:0] fr;
    bit ok;
    int lows;
    realtime t0, t1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 R2 reset state
    bus_rd(2'd1, v); chk("R2 reset status", v, 8'h10);
    bus_rd(2'd2, v); chk("R1 reset command", v, 8'h00);
    bus_rd(2'd3, v); chk("R1 reset control", v, 8'h00);
    chk("R2 reset irq", irq, 0);
    chk("R2 reset txd", txd, 1);

    // R4 rate code 0 holds the byte
    loop_en = 1;
    bus_wr(2'd0, 8'h3C);
    lows = 0;
    for (int i = 0; i < 2000; i++) begin @(negedge clk); if (!txd) lows++; end
    chk("R4 txd idle at code 0", lows, 0);
    bus_rd(2'd1, v); chk("R4 holding occupied", v, 8'h00);
    bus_wr(2'd3, 8'h0F);
    wait_rx(ok); chk("R4 byte sent after rate set", ok, 1);
    bus_rd(2'd0, v); chk("R4 held byte value", v, 8'h3C);
    bus_rd(2'd3, v); chk("R1 control readback", v, 8'h0F);

    // R3 bit length per rate code
    loop_en = 0;
    repeat (200) @(posedge clk);
    for (int c = 9; c <= 15; c++) begin
      bus_wr(2'd3, 8'(c));
      bus_wr(2'd0, 8'h55);
      wait (txd == 1'b0); t0 = $realtime;
      wait (txd == 1'b1); t1 = $realtime;
      chk($sformatf("R3 start bit code %0d", c), int'((t1 - t0) / 10.0), 16 * dv(c));
      repeat (150 * dv(c) + 40) @(posedge clk);
    end

    // R5 frame layout at code 15
    begin
      logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80};
      for (int i = 0; i < 5; i++) begin
        bus_wr(2'd0, pats[i]);
        grab_frame(dv(15), fr);
        chk("R5 start bit", fr[0], 0);
        chk("R5 data LSB first", fr[8:1], pats[i]);
        chk("R5 stop bit", fr[9], 1);
        repeat (20) @(posedge clk);
      end
    end

    // R6 loopback sweep
    loop_en = 1;
    repeat (1700) @(posedge clk);
    for (int b = 0; b < 256; b += 17) begin
      bus_wr(2'd0, 8'(b));
      wait_rx(ok); chk("R6 char received", ok, 1);
      bus_rd(2'd0, v); chk("R6 received value", v, b);
    end

    // R5 write into occupied holding register is ignored
    repeat (1700) @(posedge clk);
    bus_wr(2'd0, 8'hA1);
    bus_wr(2'd0, 8'hB2);
    bus_wr(2'd0, 8'hC3);
    wait_rx(ok); bus_rd(2'd0, v); chk("R5 first byte", v, 8'hA1);
    wait_rx(ok); bus_rd(2'd0, v); chk("R5 second byte", v, 8'hB2);
    repeat (4000) @(posedge clk);
    bus_rd(2'd1, v); chk("R5 third byte dropped", v & 8'h08, 8'h00);

    // R8 transmit hold-off
    loop_en = 0;
    bus_wr(2'd0, 8'h11);
    repeat (1500) @(posedge clk);
    bus_rd(2'd1, v); chk("R8 tx-empty held off", v & 8'h10, 8'h00);
    repeat (200) @(posedge clk);
    bus_rd(2'd1, v); chk("R8 tx-empty after char time", v & 8'h10, 8'h10);

    // R8 receive hold-off
    send_frame(8'h42, dv(15));
    wait_rx(ok);
    bus_rd(2'd0, v); chk("R6 manual frame", v, 8'h42);
    fork
      send_frame(8'h99, dv(15));
      begin
        repeat (1562) @(posedge clk);
        bus_rd(2'd1, v); chk("R8 rx-full held off", v & 8'h08, 8'h00);
        repeat (70) @(posedge clk);
        bus_rd(2'd1, v); chk("R8 rx-full after char time", v & 8'h08, 8'h08);
      end
    join
    bus_rd(2'd0, v); chk("R6 second manual frame", v, 8'h99);

    // R7 overrun
    repeat (1700) @(posedge clk);
    send_frame(8'h21, dv(15));
    send_frame(8'h84, dv(15));
    repeat (50) @(posedge clk);
    bus_rd(2'd1, v); chk("R7 overrun status", v, 8'h1C);
    bus_rd(2'd0, v); chk("R7 first byte kept", v, 8'h21);
    bus_rd(2'd1, v); chk("R7 overrun cleared by read", v, 8'h10);

    // R9 soft reset
    repeat (1700) @(posedge clk);
    send_frame(8'h5A, dv(15));
    send_frame(8'h6B, dv(15));
    bus_wr(2'd2, 8'h04);
    chk("R12 irq with tx enable", irq, 1);
    bus_wr(2'd1, 8'hAA);
    bus_rd(2'd1, v); chk("R9 status after soft reset", v, 8'h10);
    chk("R9 enables off", irq, 0);
    bus_rd(2'd2, v); chk("R9 command kept", v, 8'h04);
    bus_rd(2'd0, v); chk("R9 receive buffer cleared", v, 8'h00);

    // R10 control zero reset
    bus_wr(2'd2, 8'h04);
    chk("R11 tx enable set", irq, 1);
    bus_wr(2'd3, 8'h00);
    chk("R10 enables off", irq, 0);
    bus_rd(2'd3, v); chk("R10 control reads zero", v, 8'h00);
    bus_rd(2'd1, v); chk("R10 status", v, 8'h10);
    bus_wr(2'd3, 8'h0F);

    // R11 R12 command decode sweep
    for (int c = 0; c < 16; c++) begin
      bus_wr(2'd2, 8'(c));
      chk($sformatf("R11 irq for command %0h", c), irq, int'(c[2] && !c[3]));
      bus_rd(2'd2, v); chk("R1 command readback", v, c);
    end
    bus_wr(2'd2, 8'h08);
    chk("R12 irq idle rx enabled", irq, 0);
    send_frame(8'h77, dv(15));
    wait_rx(ok);
    chk("R12 irq on rx full", irq, 1);
    bus_wr(2'd2, 8'h0A);
    chk("R11 rx disabled by bit 1", irq, 0);
    bus_rd(2'd0, v); chk("R6 value under irq test", v, 8'h77);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule